// File: doc/BRIEF.md
# Debug Trigger Controller

This block sits between one external trigger input pin, one external trigger output pin and the on-chip debug logic. The input pin may change at any moment with no relation to the system clock. The block synchronizes it and waits for a rising level. It accepts the event only when the level stays high for a minimum number of consecutive system clocks. An accepted event becomes a single-cycle request, sent in the same cycle to the watchpoint logic and to the trace-buffer logic.

The output pin has a function chosen by a small select field that a register write port sets. With the field at zero the pin shows device readiness. Readiness is high when the device is out of reset and in neither a low-power mode nor a debug mode. With a non-zero field the pin follows one internal event source: the watchpoint monitor, the trace buffer or the performance monitor. An event on the chosen source is held high on the pin until software either writes the select field again or writes the clear bit. This keeps short events visible to an external logic analyzer. The output pin is driven from a register, so it cannot glitch when the field changes.

Top module: `dbg_trig_ctrl`

## Requirements
- R1: While reset is held, `trig_pin_o`, `wp_req_o` and `tb_req_o` are low. The select field resets to 0, so once reset is released the pin shows readiness.
- R2: `trig_in_i` passes through a two-flop synchronizer. A high level that is sampled at fewer than 3 consecutive rising clock edges produces no request. A high level sampled at exactly 3 edges produces exactly one request.
- R3: A high level of any length produces exactly one request, and that request is one cycle wide. The qualifier re-arms only after a low sample has passed the synchronizer. A single low cycle between two long highs therefore gives two requests.
- R4: `wp_req_o` and `tb_req_o` are always equal, so every accepted input reaches both consumers in the same cycle.
- R5: With the select field at 0, `trig_pin_o` equals `dev_up_i & ~low_power_i & ~debug_mode_i`, delayed by one clock.
- R6: Select value 1 picks `wp_evt_i`, 2 picks `tb_evt_i` and 3 picks `pm_evt_i`. An event on a source that is not selected leaves the pin low.
- R7: With a non-zero select and no held event, `trig_pin_o` is low.
- R8: A held event keeps the pin high after the source has dropped. Each write (`cfg_we_i` high) clears the held event, and a clear in the same cycle as an event wins. Field layout: `cfg_wdata_i[1:0]` is the new select value. `cfg_wdata_i[2]` = 1 makes the write a clear-only write that leaves the select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trig_in_i | input | 1 | Asynchronous external trigger input, active high |
| dev_up_i | input | 1 | Device has left reset |
| low_power_i | input | 1 | Device is in a low-power mode |
| debug_mode_i | input | 1 | Device is in a debug mode |
| wp_evt_i | input | 1 | Watchpoint monitor event |
| tb_evt_i | input | 1 | Trace buffer event |
| pm_evt_i | input | 1 | Performance monitor event |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Write data: [1:0] select, [2] clear-only |
| wp_req_o | output | 1 | Trigger request to the watchpoint logic |
| tb_req_o | output | 1 | Trigger request to the trace-buffer logic |
| trig_pin_o | output | 1 | External trigger output pin |

## Verification
The bench drives input highs of one, two and three clocks, which sit around the acceptance limit. A qualifier whose count is off by one would either accept the two-clock high or reject the three-clock one. Long highs, and two long highs split by a single low cycle, expose a qualifier that fires more than once per high level or that never re-arms. On the output side the bench targets three cases. An event on a source that is not selected must not set the pin. A clear-only write must drop the pin but keep the select value. A write in the same cycle as an event must win. A latch with the wrong priority or a select decode error shows up as a wrong pin level.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
   localparam int NUM_SRC = 3;
   localparam int SEL_W   = $clog2(NUM_SRC + 1);

   typedef enum logic [SEL_W-1:0] {
      OSEL_READY = 2'd0,
      OSEL_WATCH = 2'd1,
      OSEL_TRACE = 2'd2,
      OSEL_PERF  = 2'd3
   } osel_e;
endpackage

// File: rtl/dbg_trig_sync.sv
module dbg_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("dbg_trig_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (!rst_ni) chain_q[i] <= 1'b0;
               else         chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_trig_qual.sv
module dbg_trig_qual #(
   parameter int MIN_HIGH = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic pulse_o
);
   localparam int CNT_W = $clog2(MIN_HIGH + 1);
   localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(MIN_HIGH - 1);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_HIGH);

   logic [CNT_W-1:0] run_q;
   logic             hit;
   logic             pulse_q;

   generate
      if (MIN_HIGH < 1) begin : g_bad
         $error("dbg_trig_qual: MIN_HIGH must be at least 1");
      end
   endgenerate

   assign hit = lvl_i && (run_q == CNT_HIT);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= hit;
         if (!lvl_i)              run_q <= '0;
         else if (run_q != CNT_SAT) run_q <= run_q + 1'b1;
      end
   end

   assign pulse_o = pulse_q;

   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q |=> !pulse_q); // R3
   AST_PULSE_NEEDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q |-> $past(lvl_i)); // R2
endmodule

// File: rtl/dbg_trig_cfg.sv
module dbg_trig_cfg
   import dbg_trig_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [SEL_W:0]   wdata_i,
   output osel_e            sel_o,
   output logic             clr_o
);
   osel_e sel_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) sel_q <= OSEL_READY;
      else if (we_i && !wdata_i[SEL_W]) sel_q <= osel_e'(wdata_i[SEL_W-1:0]);
   end

   assign sel_o = sel_q;
   assign clr_o = we_i;

   AST_SEL_KEEP_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wdata_i[SEL_W]) |=> $stable(sel_q)); // R8
   AST_SEL_KEEP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(sel_q)); // R8
endmodule

// File: rtl/dbg_trig_outsel.sv
module dbg_trig_outsel
   import dbg_trig_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  osel_e              sel_i,
   input  logic               clr_i,
   input  logic [NUM_SRC-1:0] src_evt_i,
   input  logic               rdy_i,
   output logic               pin_o
);
   logic evt_sel;
   logic latch_q;
   logic pin_d;

   always_comb begin
      evt_sel = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel_i == osel_e'(i + 1)) evt_sel = src_evt_i[i];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      latch_q <= 1'b0;
      else if (clr_i)   latch_q <= 1'b0;
      else if (evt_sel) latch_q <= 1'b1;
   end

   assign pin_d = (sel_i == OSEL_READY) ? rdy_i : latch_q;

   generate
      if (OUT_REG) begin : g_reg
         logic pin_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) pin_q <= 1'b0;
            else         pin_q <= pin_d;
         end
         assign pin_o = pin_q;

         AST_PIN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sel_i == OSEL_READY) |=> (pin_q == $past(rdy_i))); // R5
         AST_PIN_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sel_i != OSEL_READY && !latch_q) |=> !pin_q); // R7
      end else begin : g_comb
         assign pin_o = pin_d;
      end
   endgenerate

   AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_q && !clr_i) |=> latch_q); // R8
endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
   import dbg_trig_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_HIGH    = 3,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           trig_in_i,
   input  logic           dev_up_i,
   input  logic           low_power_i,
   input  logic           debug_mode_i,
   input  logic           wp_evt_i,
   input  logic           tb_evt_i,
   input  logic           pm_evt_i,
   input  logic           cfg_we_i,
   input  logic [SEL_W:0] cfg_wdata_i,
   output logic           wp_req_o,
   output logic           tb_req_o,
   output logic           trig_pin_o
);
   logic               in_lvl;
   logic               in_pulse;
   osel_e              sel;
   logic               clr;
   logic               rdy;
   logic [NUM_SRC-1:0] src_evt;

   dbg_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (trig_in_i), .q_o (in_lvl)
   );

   dbg_trig_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
      .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (in_lvl), .pulse_o (in_pulse)
   );

   dbg_trig_cfg u_cfg (
      .clk_i (clk_i), .rst_ni (rst_ni), .we_i (cfg_we_i),
      .wdata_i (cfg_wdata_i), .sel_o (sel), .clr_o (clr)
   );

   assign rdy     = dev_up_i & ~low_power_i & ~debug_mode_i;
   assign src_evt = {pm_evt_i, tb_evt_i, wp_evt_i};

   dbg_trig_outsel #(.OUT_REG(OUT_REG)) u_out (
      .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (sel), .clr_i (clr),
      .src_evt_i (src_evt), .rdy_i (rdy), .pin_o (trig_pin_o)
   );

   assign wp_req_o = in_pulse;
   assign tb_req_o = in_pulse;
endmodule

// File: tb/tb_dbg_trig_ctrl.sv
module tb_dbg_trig_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig_in = 1'b0;
   logic       dev_up = 1'b0, low_power = 1'b0, debug_mode = 1'b0;
   logic       wp_evt = 1'b0, tb_evt = 1'b0, pm_evt = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_wdata = 3'b000;
   logic       wp_req, tb_req, trig_pin;

   int checks = 0;
   int errors = 0;
   int npulse = 0;
   int nwide  = 0;
   int nmism  = 0;
   logic prev_req = 1'b0;

   always #4 clk = ~clk;

   dbg_trig_ctrl dut (
      .clk_i (clk), .rst_ni (rst_n), .trig_in_i (trig_in),
      .dev_up_i (dev_up), .low_power_i (low_power), .debug_mode_i (debug_mode),
      .wp_evt_i (wp_evt), .tb_evt_i (tb_evt), .pm_evt_i (pm_evt),
      .cfg_we_i (cfg_we), .cfg_wdata_i (cfg_wdata),
      .wp_req_o (wp_req), .tb_req_o (tb_req), .trig_pin_o (trig_pin)
   );

   always @(negedge clk) begin
      if (wp_req) npulse++;
      if (wp_req && prev_req) nwide++;
      if (wp_req != tb_req) nmism++;
      prev_req = wp_req;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic clr_only, input logic [1:0] s);
      cfg_we = 1'b1; cfg_wdata = {clr_only, s};
      cyc(1);
      cfg_we = 1'b0; cfg_wdata = 3'b000;
   endtask

   task automatic ev(input int idx);
      wp_evt = (idx == 1); tb_evt = (idx == 2); pm_evt = (idx == 3);
      cyc(1);
      wp_evt = 1'b0; tb_evt = 1'b0; pm_evt = 1'b0;
   endtask

   task automatic hi_pulse(input int n);
      trig_in = 1'b1; cyc(n); trig_in = 1'b0; cyc(8);
   endtask

   task automatic t_reset();
      cyc(3);
      chk("R1 pin in reset", trig_pin, 0);
      chk("R1 req in reset", wp_req | tb_req, 0);
      dev_up = 1'b1;
      rst_n = 1'b1;
      cyc(3);
      chk("R1 ready after reset", trig_pin, 1);
   endtask

   task automatic t_short();
      for (int n = 1; n <= 3; n++) begin
         npulse = 0;
         hi_pulse(n);
         chk($sformatf("R2 high for %0d clocks", n), npulse, (n >= 3) ? 1 : 0);
      end
   endtask

   task automatic t_long();
      npulse = 0; nwide = 0;
      hi_pulse(25);
      chk("R3 long high one request", npulse, 1);
      chk("R3 request one cycle wide", nwide, 0);
      npulse = 0;
      trig_in = 1'b1; cyc(10); trig_in = 1'b0; cyc(1);
      trig_in = 1'b1; cyc(6); trig_in = 1'b0; cyc(8);
      chk("R3 re-arm after one low", npulse, 2);
      chk("R4 requests equal", nmism, 0);
   endtask

   task automatic t_ready();
      wr(1'b0, 2'd0);
      for (int k = 0; k < 8; k++) begin
         {dev_up, low_power, debug_mode} = 3'(k);
         cyc(2);
         chk($sformatf("R5 ready combo %0d", k), trig_pin,
             (dev_up && !low_power && !debug_mode) ? 1 : 0);
      end
      dev_up = 1'b1; low_power = 1'b0; debug_mode = 1'b0;
   endtask

   task automatic t_select();
      for (int s = 1; s <= 3; s++) begin
         wr(1'b0, 2'(s));
         cyc(2);
         chk($sformatf("R7 idle low sel %0d", s), trig_pin, 0);
         ev((s % 3) + 1);
         cyc(3);
         chk($sformatf("R6 other source ignored sel %0d", s), trig_pin, 0);
         ev(s);
         cyc(3);
         chk($sformatf("R6 selected source sel %0d", s), trig_pin, 1);
         cyc(5);
         chk($sformatf("R8 held sel %0d", s), trig_pin, 1);
         wr(1'b1, 2'd0);
         cyc(2);
         chk($sformatf("R8 clear-only drops pin sel %0d", s), trig_pin, 0);
         ev(s);
         cyc(3);
         chk($sformatf("R8 clear-only kept select %0d", s), trig_pin, 1);
         wr(1'b0, 2'(s));
         cyc(2);
         chk($sformatf("R8 rewrite clears sel %0d", s), trig_pin, 0);
      end
      wp_evt = 1'b1; tb_evt = 1'b1; pm_evt = 1'b1;
      cfg_we = 1'b1; cfg_wdata = 3'b100;
      cyc(1);
      cfg_we = 1'b0; wp_evt = 1'b0; tb_evt = 1'b0; pm_evt = 1'b0;
      cyc(3);
      chk("R8 clear wins over event", trig_pin, 0);
      ev(3);
      cyc(2);
      wr(1'b0, 2'd0);
      cyc(2);
      chk("R5 ready after select back to 0", trig_pin, 1);
   endtask

   initial begin
      t_reset();
      t_short();
      t_long();
      t_ready();
      t_select();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule